// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Mode Control

This block compares a reference pulse train against a divided-oscillator pulse train and drives the source and sink enables of an external charge pump. The enable that is active, and for how long, tells the loop whether the oscillator lags or leads. Each input pulse is one clock cycle wide and synchronous to the block clock.

Around the detector sits a small mode layer. One input picks the pump current level. One input switches the tuning amplifier off and parks the pump in sink. A three-bit test code can hold the pump off, force sink or force source. The same code can also route either the reference pulses or a half-rate copy of the divided pulses onto two band-output routes.

A lock monitor measures the distance between the two edges of each comparison. It raises a lock flag once enough consecutive comparisons land inside a small window of clock cycles.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: `cur_hi` equals `cp_hi` in the same cycle (0 selects low pump current, 1 selects high).
- R2: In normal mode, a reference pulse that comes d cycles before a divided pulse holds `pump_up` high for exactly d cycles, starting the cycle after the reference pulse. The mirror case drives `pump_dn`. Coincident pulses produce neither.
- R3: With `os_off`=1, `amp_en`=0, `pump_dn`=1 and `pump_up`=0 whatever the test code. With `os_off`=0, `amp_en`=1.
- R4: `test_code` is {T2,T1,T0} with T2 as bit 2. Codes 000, 001, 100 and 101 leave the pump under detector control. Codes 010 and 011 hold both enables low.
- R5: Code 110 gives `pump_dn`=1 and `pump_up`=0. Code 111 gives `pump_up`=1 and `pump_dn`=0.
- R6: Code 100 sets `b4_route_en` and drives `b4_route` with `ref_pulse` combinationally. Code 101 sets `b2_route_en` and drives `b2_route` with a level that is 0 after reset and toggles on every divided pulse. Under any other code both routes and both enables are 0.
- R7: `locked` (1 = locked, 0 = unlocked) rises in the cycle after the fourth consecutive comparison whose edge distance is at most WIN cycles.
- R8: The first comparison whose distance exceeds WIN clears `locked` and restarts the count. A repeated pulse of the same kind before its partner arrives counts as such a comparison.
- R9: After reset both pump enables, both routes and `locked` are 0 (with `os_off`=0 and code 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle reference pulse |
| div_pulse | input | 1 | One-cycle divided-oscillator pulse |
| cp_hi | input | 1 | Pump current select request |
| os_off | input | 1 | Tuning amplifier off request |
| test_code | input | 3 | Test code {T2,T1,T0} |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| cur_hi | output | 1 | High pump current select |
| amp_en | output | 1 | Tuning amplifier enable |
| b4_route_en | output | 1 | Band 4 carries the test route |
| b4_route | output | 1 | Reference pulse route |
| b2_route_en | output | 1 | Band 2 carries the test route |
| b2_route | output | 1 | Half-rate divided route |
| locked | output | 1 | Lock flag |

## Verification
The properties assume that both pulse inputs are single-cycle and synchronous to the clock. They also assume that each reference pulse is paired with a divided pulse before either repeats, and that mode inputs change only between comparisons. The stimulus issues whole comparisons as one pulse of each kind with a chosen signed offset, followed by at least two idle cycles. It changes the mode inputs only in those idle gaps. Offsets are drawn mostly inside the window so that lock is reached and lost many times, and directed runs sit exactly on and one past the window edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_OFF    = 2'd1,
    PM_SINK   = 2'd2,
    PM_SOURCE = 2'd3
  } pump_mode_e;

  // Amplifier off dominates; then the upper two test bits choose the mode.
  function automatic pump_mode_e decode_mode(input logic amp_off, input logic [2:0] code);
    pump_mode_e m;
    if (amp_off) begin
      m = PM_SINK;
    end else begin
      unique case (code[2:1])
        2'b01:   m = PM_OFF;
        2'b11:   m = code[0] ? PM_SOURCE : PM_SINK;
        default: m = PM_NORMAL;
      endcase
    end
    return m;
  endfunction

  function automatic logic gap_ok(input int unsigned gap, input int unsigned win);
    return gap <= win;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic div_pulse,
  output logic det_up,
  output logic det_dn,
  output logic half_q
);
  logic up_nxt, dn_nxt, both;

  always_comb begin
    up_nxt = det_up | ref_pulse;
    dn_nxt = det_dn | div_pulse;
    both   = up_nxt & dn_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_up <= 1'b0;
      det_dn <= 1'b0;
      half_q <= 1'b0;
    end else begin
      det_up <= up_nxt & ~both;
      det_dn <= dn_nxt & ~both;
      half_q <= half_q ^ div_pulse;
    end
  end
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int unsigned WIN    = 2,
  parameter int unsigned LOCK_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic div_pulse,
  output logic pair_done,
  output logic pair_good,
  output logic pair_miss,
  output logic locked
);
  import pfd_pkg::*;

  localparam int unsigned GW  = $clog2(WIN + 3);
  localparam int unsigned CW  = $clog2(LOCK_N + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(WIN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOCK_N);

  logic          pending, pend_ref;
  logic [GW-1:0] gap_cnt;
  logic [GW:0]   gap_now;
  logic [CW-1:0] good_cnt;
  logic          start_new, start_ref, partner, repeat_p;

  always_comb begin
    gap_now   = {1'b0, gap_cnt} + 1'b1;
    pair_done = 1'b0;
    pair_good = 1'b0;
    pair_miss = 1'b0;
    start_new = 1'b0;
    start_ref = ref_pulse;
    partner   = pend_ref ? div_pulse : ref_pulse;
    repeat_p  = pend_ref ? ref_pulse : div_pulse;
    if (!pending) begin
      if (ref_pulse && div_pulse) begin
        pair_done = 1'b1;
        pair_good = 1'b1;
      end else if (ref_pulse || div_pulse) begin
        start_new = 1'b1;
      end
    end else begin
      if (partner) begin
        pair_done = 1'b1;
        pair_good = gap_ok(32'(gap_now), WIN);
        pair_miss = ~pair_good;
        if (repeat_p) begin
          start_new = 1'b1;
          start_ref = pend_ref;
        end
      end else if (repeat_p) begin
        pair_miss = 1'b1;
        start_new = 1'b1;
        start_ref = pend_ref;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      pend_ref <= 1'b0;
      gap_cnt  <= '0;
      good_cnt <= '0;
    end else begin
      if (start_new) begin
        pending  <= 1'b1;
        pend_ref <= start_ref;
        gap_cnt  <= '0;
      end else if (pair_done) begin
        pending  <= 1'b0;
      end else if (pending && gap_cnt != GAP_SAT) begin
        gap_cnt  <= gap_cnt + 1'b1;
      end
      if (pair_miss)
        good_cnt <= '0;
      else if (pair_good && good_cnt != CNT_MAX)
        good_cnt <= good_cnt + 1'b1;
    end
  end

  assign locked = (good_cnt == CNT_MAX);
endmodule

// File: rtl/pump_mode_ctrl.sv
module pump_mode_ctrl (
  input  logic       amp_off,
  input  logic [2:0] code,
  input  logic       det_up,
  input  logic       det_dn,
  input  logic       ref_pulse,
  input  logic       half_q,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       amp_en,
  output logic       b4_route_en,
  output logic       b4_route,
  output logic       b2_route_en,
  output logic       b2_route
);
  import pfd_pkg::*;

  pump_mode_e mode;

  always_comb begin
    mode = decode_mode(amp_off, code);
    unique case (mode)
      PM_OFF:    begin pump_up = 1'b0;   pump_dn = 1'b0;   end
      PM_SINK:   begin pump_up = 1'b0;   pump_dn = 1'b1;   end
      PM_SOURCE: begin pump_up = 1'b1;   pump_dn = 1'b0;   end
      default:   begin pump_up = det_up; pump_dn = det_dn; end
    endcase
    amp_en      = ~amp_off;
    b4_route_en = (code == 3'b100);
    b2_route_en = (code == 3'b101);
    b4_route    = b4_route_en & ref_pulse;
    b2_route    = b2_route_en & half_q;
  end
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
  parameter int unsigned WIN    = 2,
  parameter int unsigned LOCK_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       div_pulse,
  input  logic       cp_hi,
  input  logic       os_off,
  input  logic [2:0] test_code,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       cur_hi,
  output logic       amp_en,
  output logic       b4_route_en,
  output logic       b4_route,
  output logic       b2_route_en,
  output logic       b2_route,
  output logic       locked
);
  logic det_up, det_dn, half_q;
  logic pair_done, pair_good, pair_miss;

  pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .det_up(det_up), .det_dn(det_dn), .half_q(half_q)
  );

  lock_monitor #(.WIN(WIN), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .pair_done(pair_done), .pair_good(pair_good), .pair_miss(pair_miss),
    .locked(locked)
  );

  pump_mode_ctrl u_mode (
    .amp_off(os_off), .code(test_code), .det_up(det_up), .det_dn(det_dn),
    .ref_pulse(ref_pulse), .half_q(half_q),
    .pump_up(pump_up), .pump_dn(pump_dn), .amp_en(amp_en),
    .b4_route_en(b4_route_en), .b4_route(b4_route),
    .b2_route_en(b2_route_en), .b2_route(b2_route)
  );

  assign cur_hi = cp_hi;
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_pulse,
  input logic       div_pulse,
  input logic       os_off,
  input logic [2:0] test_code,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       amp_en,
  input logic       det_up,
  input logic       det_dn,
  input logic       half_q,
  input logic       pair_good,
  input logic       pair_miss,
  input logic       locked
);
  // R2
  det_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_up && det_dn));

  // R2
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_up) |-> $past(ref_pulse));

  // R4
  normal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_off && test_code[2:1] == 2'b00) |-> (pump_up == det_up && pump_dn == det_dn));

  // R3
  amp_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_off |-> (pump_dn && !pump_up && !amp_en));

  // R6
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_q) |-> $past(div_pulse));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pair_good));

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pair_miss));
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
  .os_off(os_off), .test_code(test_code), .pump_up(pump_up), .pump_dn(pump_dn),
  .amp_en(amp_en), .det_up(det_up), .det_dn(det_dn), .half_q(half_q),
  .pair_good(pair_good), .pair_miss(pair_miss), .locked(locked)
);

// File: tb/sim_pfd_pump_ctrl.sv
module sim_pfd_pump_ctrl;
  localparam int WIN    = 2;
  localparam int LOCK_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_r = 1'b0, div_r = 1'b0, cp_r = 1'b0, os_r = 1'b0;
  logic [2:0] code_r = 3'b000;
  logic pump_up, pump_dn, cur_hi, amp_en, b4_en, b4_v, b2_en, b2_v, locked;

  int checks = 0, fails = 0;
  int cnt_up = 0, cnt_dn = 0;
  int run = 0;
  logic div_par = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  pfd_pump_ctrl #(.WIN(WIN), .LOCK_N(LOCK_N)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_r), .div_pulse(div_r),
    .cp_hi(cp_r), .os_off(os_r), .test_code(code_r),
    .pump_up(pump_up), .pump_dn(pump_dn), .cur_hi(cur_hi), .amp_en(amp_en),
    .b4_route_en(b4_en), .b4_route(b4_v), .b2_route_en(b2_en), .b2_route(b2_v),
    .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {forced, up, dn}: forced=0 means the detector drives the pump.
  function automatic logic [2:0] forced_pump(input logic os, input logic [2:0] c);
    if (os)             return 3'b101;
    if (c == 3'b010 || c == 3'b011) return 3'b100;
    if (c == 3'b110)    return 3'b101;
    if (c == 3'b111)    return 3'b110;
    return 3'b000;
  endfunction

  task automatic step(input logic r, input logic d);
    logic [2:0] f;
    @(negedge clk);
    ref_r = r;
    div_r = d;
    @(posedge clk);
    #2;
    if (d) div_par = ~div_par;
    f = forced_pump(os_r, code_r);
    chk(cur_hi == cp_r, "R1 cur_hi", int'(cur_hi), int'(cp_r));
    chk(amp_en == !os_r, "R3 amp_en", int'(amp_en), int'(!os_r));
    if (f[2]) begin
      chk(pump_up == f[1], os_r ? "R3 forced up" : "R5/R4 forced up", int'(pump_up), int'(f[1]));
      chk(pump_dn == f[0], os_r ? "R3 forced dn" : "R5/R4 forced dn", int'(pump_dn), int'(f[0]));
    end
    chk(b4_en == (code_r == 3'b100) && b4_v == ((code_r == 3'b100) && r),
        "R6 band4 route", int'({b4_en, b4_v}), int'({code_r == 3'b100, (code_r == 3'b100) && r}));
    chk(b2_en == (code_r == 3'b101) && b2_v == ((code_r == 3'b101) && div_par),
        "R6 band2 route", int'({b2_en, b2_v}), int'({code_r == 3'b101, (code_r == 3'b101) && div_par}));
    if (pump_up) cnt_up++;
    if (pump_dn) cnt_dn++;
  endtask

  // One comparison: dd>0 reference leads by dd cycles, dd<0 divided leads.
  task automatic pair(input int dd, input int idle);
    int mag;
    bit detector_mode;
    mag = (dd < 0) ? -dd : dd;
    cnt_up = 0;
    cnt_dn = 0;
    detector_mode = (forced_pump(os_r, code_r)[2] == 1'b0);
    if (dd == 0) begin
      step(1'b1, 1'b1);
    end else if (dd > 0) begin
      step(1'b1, 1'b0);
      for (int i = 1; i < mag; i++) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end else begin
      step(1'b0, 1'b1);
      for (int i = 1; i < mag; i++) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end
    if (mag <= WIN) begin
      if (run < LOCK_N) run++;
      chk(locked == (run >= LOCK_N), "R7 lock count", int'(locked), int'(run >= LOCK_N));
    end else begin
      run = 0;
      chk(locked == 1'b0, "R8 lock drop", int'(locked), 0);
    end
    if (detector_mode) begin
      chk(cnt_up == ((dd > 0) ? dd : 0), "R2 up width", cnt_up, (dd > 0) ? dd : 0);
      chk(cnt_dn == ((dd < 0) ? -dd : 0), "R2 dn width", cnt_dn, (dd < 0) ? -dd : 0);
    end
    for (int i = 0; i < idle; i++) step(1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int dd;
    int pick;
    void'($urandom(32'd1384));
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk(pump_up == 0 && pump_dn == 0, "R9 pumps in reset", int'({pump_up, pump_dn}), 0);
    chk(locked == 0 && b2_v == 0 && b4_v == 0, "R9 flags in reset", int'({locked, b2_v, b4_v}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk(pump_up == 0 && pump_dn == 0 && locked == 0, "R9 after reset", int'({pump_up, pump_dn, locked}), 0);

    // Directed lock build-up at the window edge (R7), then one step past (R8)
    pair(WIN, 3);
    pair(-WIN, 3);
    pair(0, 3);
    pair(1, 3);
    pair(WIN + 1, 3);
    pair(-1, 2);

    // Directed test codes (R4, R5, R6) and amplifier off (R3)
    code_r = 3'b011; pair(2, 2);
    code_r = 3'b110; pair(-1, 2);
    code_r = 3'b111; pair(1, 2);
    code_r = 3'b100; pair(2, 2);
    code_r = 3'b101; pair(-2, 2); pair(1, 2); pair(0, 2);
    code_r = 3'b001; pair(3, 2);
    code_r = 3'b000; os_r = 1'b1; code_r = 3'b111; pair(1, 2);
    os_r = 1'b0; code_r = 3'b000; cp_r = 1'b1; pair(-3, 2);

    // Constrained random comparisons
    for (int n = 0; n < 400; n++) begin
      pick = int'($urandom_range(0, 99));
      if (pick < 75) dd = int'($urandom_range(0, 2 * WIN)) - WIN;
      else           dd = int'($urandom_range(0, 10)) - 5;
      pick = int'($urandom_range(0, 15));
      if (pick < 9) code_r = 3'b000;
      else          code_r = 3'($urandom_range(0, 7));
      os_r = ($urandom_range(0, 7) == 0);
      cp_r = 1'($urandom_range(0, 1));
      pair(dd, int'($urandom_range(2, 5)));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule